// File: doc/BRIEF.md
# SPI Master Baud Rate Generator

This block sets the serial clock timing of an SPI master. An 8-bit rate register holds two fields: a prescale factor from 1 to 8 and a power-of-two exponent. The bus clock is divided by the prescale factor times a power of two. While the shift engine asserts `run`, the block emits a one-cycle `sck_tick` at every half period of the serial clock. The shift engine toggles SCK on each tick, so one full SCK period spans the whole divisor. The complete divisor is also presented as a number.

Software can read and write the register in any cycle. A write that changes the rate restarts the divider from zero, so the first edge at the new rate comes a full half period after the write. If master mode is enabled when such a write happens, the block raises a single-cycle abort request. The shift engine uses it to drop the transfer in progress and return to idle.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is held and after it is released, `rd_data` reads 0x00, `divisor` reads 2, and `sck_tick` and `abort_req` are low.
- R2: With the prescale field P in register bits 6..4 and the exponent field S in bits 2..0, `divisor` equals (P+1)·2^(S+1). It ranges from 2 to 2048.
- R3: Register bits 7 and 3 always read as zero, and the values written to them have no effect.
- R4: While `run` is high, `sck_tick` is high for exactly one cycle in every divisor/2 cycles. The first tick falls in the (divisor/2)-th cycle of `run` being high, counted from the first edge with `run` high.
- R5: While `run` is low, `sck_tick` stays low and the divider returns to zero. Raising `run` again restarts the R4 timing.
- R6: A write whose bits 6..4 or 2..0 differ from the stored fields restarts the divider on that write edge. The next tick then comes divisor/2 cycles later at the new rate.
- R7: Such a changing write made while `master_en` is high raises `abort_req` in the cycle after the write edge, for that one cycle only. A changing write with `master_en` low raises no abort.
- R8: A write that leaves bits 6..4 and 2..0 unchanged raises no abort and does not disturb the tick timing.
- R9: A write takes effect on its clock edge in any cycle, including while `run` is high. `rd_data` shows the new fields from the next cycle and otherwise stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_en | input | 1 | High when the SPI operates as master |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| run | input | 1 | Shift engine requests serial clock timing |
| rd_data | output | 8 | Register read data |
| sck_tick | output | 1 | One-cycle pulse at each SCK half period |
| divisor | output | 12 | Bus clocks per full SCK period |
| abort_req | output | 1 | One-cycle request to abort the transfer and go idle |

## Verification
The bound checker checks the following on every cycle:
- the reserved read bits are zero;
- the divisor stays within its range;
- no tick occurs without `run`;
- the register holds its value when there is no write;
- an abort appears only after a master-mode write, and only after one that changes a field;
- a restarting write suppresses the next tick.

The exact tick spacing and the placement of the first tick after a restart are shown only by the bench's reference model. The same holds for the divisor value of each field pair and for the masking of reserved bits during mixed writes. The model follows the bench's scenarios cycle by cycle: a sweep of all 64 rates, run gating, and same-value and mode-dependent writes.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int REG_W    = 8;
  localparam int PRE_W    = 3;
  localparam int SEL_W    = 3;
  localparam int PRE_LSB  = 4;
  localparam int SEL_LSB  = 0;
  // power-of-two counter width: largest half-period factor is 2^(2^SEL_W - 1)
  localparam int POW_W    = (1 << SEL_W) - 1;
  // full divisor width: (2^PRE_W) * 2^(2^SEL_W) needs this many bits
  localparam int DIV_W    = PRE_W + (1 << SEL_W) + 1;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
  } rate_t;

  function automatic rate_t unpack_rate(input logic [REG_W-1:0] word);
    rate_t r;
    r.pre = word[PRE_LSB +: PRE_W];
    r.sel = word[SEL_LSB +: SEL_W];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_rate(input rate_t r);
    logic [REG_W-1:0] word;
    word = '0;
    word[PRE_LSB +: PRE_W] = r.pre;
    word[SEL_LSB +: SEL_W] = r.sel;
    return word;
  endfunction
endpackage

// File: rtl/spi_baud_rstsync.sv
module spi_baud_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output rate_t            rate,
  output logic [REG_W-1:0] rd_data,
  output logic             restart,
  output logic             abort_req
);
  rate_t rate_q;
  rate_t wr_rate;
  logic  abort_q;
  logic  abort_d;

  always_comb begin
    wr_rate = unpack_rate(wr_data);
    restart = wr_en && (wr_rate != rate_q);
    abort_d = restart && master_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (restart) begin
      rate_q <= wr_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= abort_d;
  end

  assign rate      = rate_q;
  assign rd_data   = pack_rate(rate_q);
  assign abort_req = abort_q;
endmodule

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             carry
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    carry = run && (cnt_q == limit);
    if (clr || !run)  cnt_d = '0;
    else if (carry)   cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_baud_pow2.sv
module spi_baud_pow2
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             wrap
);
  logic [POW_W-1:0] mask;
  logic [POW_W-1:0] cnt_q;
  logic [POW_W-1:0] cnt_d;

  // terminal count 2^sel - 1 as a thermometer mask
  for (genvar i = 0; i < POW_W; i++) begin : g_mask
    assign mask[i] = (sel > SEL_W'(i));
  end

  always_comb begin
    wrap = step && (cnt_q == mask);
    if (clr || !run)  cnt_d = '0;
    else if (wrap)    cnt_d = '0;
    else if (step)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             run,
  output logic [7:0]       rd_data,
  output logic             sck_tick,
  output logic [11:0]      divisor,
  output logic             abort_req
);
  logic             rst_n_i;
  rate_t            rate;
  logic             restart;
  logic             pre_carry;
  logic [DIV_W-1:0] base;

  spi_baud_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  spi_baud_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .master_en (master_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rate      (rate),
    .rd_data   (rd_data),
    .restart   (restart),
    .abort_req (abort_req)
  );

  spi_baud_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (restart),
    .run   (run),
    .limit (rate.pre),
    .carry (pre_carry)
  );

  spi_baud_pow2 u_pow (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (restart),
    .run   (run),
    .step  (pre_carry),
    .sel   (rate.sel),
    .wrap  (sck_tick)
  );

  always_comb begin
    base    = DIV_W'(rate.pre) + DIV_W'(1);
    divisor = base << ({1'b0, rate.sel} + 4'd1);
  end
endmodule

// File: rtl/spi_baud_chk.sv
module spi_baud_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        master_en,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic        run,
  input logic [7:0]  rd_data,
  input logic        sck_tick,
  input logic [11:0] divisor,
  input logic        abort_req
);
  logic fields_change;
  assign fields_change = wr_en &&
    ({wr_data[6:4], wr_data[2:0]} != {rd_data[6:4], rd_data[2:0]});

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] == 1'b0) && (rd_data[3] == 1'b0));

  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor >= 12'd2) && (divisor <= 12'd2048));

  assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick |-> run);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(master_en && wr_en));

  assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !abort_req);

  assert_same_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fields_change) |=> !abort_req);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fields_change && run) |=> (!sck_tick || divisor == 12'd2));
endmodule

bind spi_baud_gen spi_baud_chk u_chk (.*);

// File: tb/tb_spi_baud_gen.sv
module tb_spi_baud_gen;
  logic        clk;
  logic        rst_n;
  logic        master_en;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        run;
  logic [7:0]  rd_data;
  logic        sck_tick;
  logic [11:0] divisor;
  logic        abort_req;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  string phase = "R1 reset";

  // behavioural reference state
  int m_pre, m_sel, m_cnt;
  bit m_abort;

  spi_baud_gen dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int half_period();
    return (m_pre + 1) * (1 << m_sel);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_sel = 0; m_cnt = 0; m_abort = 0;
    end else begin
      int np, ns, h;
      bit chg;
      np  = int'(wr_data[6:4]);
      ns  = int'(wr_data[2:0]);
      chg = wr_en && ((np != m_pre) || (ns != m_sel));
      h   = half_period();
      m_abort = chg && master_en;
      if (!run || chg)       m_cnt = 0;
      else if (m_cnt == h-1) m_cnt = 0;
      else                   m_cnt = m_cnt + 1;
      if (chg) begin m_pre = np; m_sel = ns; end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s] got %0d expected %0d", tag, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int h;
      h = half_period();
      chk("R4 sck_tick", int'(sck_tick), (run && m_cnt == h-1) ? 1 : 0);
      chk("R2 divisor", int'(divisor), 2*h);
      chk("R9 rd_data", int'(rd_data), (m_pre << 4) | m_sel);
      chk("R7 abort_req", int'(abort_req), int'(m_abort));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [7:0] v);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; master_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00; run = 1'b0;
    #1;
    chk("R1 rd_data in reset", int'(rd_data), 0);
    chk("R1 divisor in reset", int'(divisor), 2);
    chk("R1 abort in reset", int'(abort_req), 0);
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    @(negedge clk);
    chk("R1 sck_tick after reset", int'(sck_tick), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    cycles(1);

    phase = "R4 fastest rate";
    master_en = 1'b1; run = 1'b1;
    cycles(10);

    phase = "R6 R7 changing write while running";
    do_write(8'h13);
    @(negedge clk);
    chk("R7 abort after change", int'(abort_req), 1);
    chk("R9 readback 0x13", int'(rd_data), 8'h13);
    cycles(40);

    phase = "R8 same value write";
    do_write(8'h13);
    @(negedge clk);
    chk("R8 no abort on same value", int'(abort_req), 0);
    cycles(5);

    phase = "R3 reserved-only write";
    do_write(8'h9B & 8'hFB | 8'h80);
    @(negedge clk);
    chk("R3 reserved bits ignored", int'(rd_data), 8'h13);
    chk("R8 reserved-only no abort", int'(abort_req), 0);
    cycles(20);

    phase = "R7 slave-mode change";
    master_en = 1'b0;
    do_write(8'hAD);
    @(negedge clk);
    chk("R7 no abort outside master", int'(abort_req), 0);
    chk("R3 reserved masked on readback", int'(rd_data), 8'h25);
    cycles(60);
    master_en = 1'b1;

    phase = "R5 run gating";
    run = 1'b0;
    cycles(7);
    @(negedge clk);
    chk("R5 no tick while idle", int'(sck_tick), 0);
    run = 1'b1;
    cycles(50);

    phase = "R2 R4 sweep of all rates";
    for (int v = 0; v < 64; v++) begin
      logic [7:0] w;
      int h;
      w = {1'b0, v[5:3], 1'b0, v[2:0]};
      if (v[0]) w = w | 8'h88;
      h = (int'(v[5:3]) + 1) * (1 << int'(v[2:0]));
      do_write(w);
      cycles(2*h + 2);
    end

    phase = "R2 slowest divisor";
    do_write(8'h77);
    @(negedge clk);
    chk("R2 divisor 2048", int'(divisor), 2048);
    cycles(2100);

    phase = "R6 mid-period rate change";
    do_write(8'h02);
    cycles(3);
    do_write(8'h70);
    cycles(30);

    cycles(2);
    finish_run();
  end
endmodule